// File: doc/BRIEF.md
# Single-Cycle Eight-Instruction Processor Core

This block is a small processor core that runs one instruction to completion on every rising clock edge. It supports word loads and stores, an equality branch, and five register-to-register operations: add, subtract, AND, OR and signed set-less-than. The program counter, an instruction word array, a data word array, a 32-entry register file, the ALU and the decode logic all sit inside the block.

Control is split from the datapath. A main decoder turns the 6-bit opcode into a set of strobes and a 2-bit ALU operation class. A second decode stage uses that class, and the function field only for the shared register-to-register opcode, to pick the ALU function. The datapath is steered only by that strobe bundle.

Programs and data are written through a load port while reset is held. After reset is released the core runs from address 0. A debug port reads any register combinationally, and the current program counter is always visible.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low, `pcOut` is 0 and every register reads 0 through the debug port. Reset clears the registers, even if an earlier run wrote them.
- R2: Opcode 6'h00 with function 6'h20 (add) or 6'h22 (sub) writes rs+rt or rs-rt into rd. The fields are rs = bits 25:21, rt = bits 20:16, rd = bits 15:11 and function = bits 5:0.
- R3: Opcode 6'h00 with function 6'h24 writes rs AND rt into rd. Function 6'h25 writes rs OR rt into rd.
- R4: Opcode 6'h00 with function 6'h2A writes 1 into rd when rs < rt as signed 32-bit values, and 0 otherwise. Equal operands give 0.
- R5: Opcode 6'h23 (load) writes the data word at byte address rs + sign-extended bits 15:0 into rt. Negative offsets are supported.
- R6: Opcode 6'h2B (store) writes rt into the data word at byte address rs + sign-extended bits 15:0. A store writes no register, including the register named by bits 15:11.
- R7: Opcode 6'h04 (branch-if-equal) sets the next PC to PC+4 + (sign-extended bits 15:0 << 2) when rs equals rt, and to PC+4 otherwise. Backward and self-targeting offsets are supported.
- R8: Register 0 always reads 0, and any write to it has no effect.
- R9: Each clock after reset release retires one instruction. `pcOut` advances by 4 on every edge unless a branch is taken.
- R10: An opcode outside 6'h00, 6'h23, 6'h2B and 6'h04 writes no register and no data word, and the next PC is PC+4.
- R11: With `loadEn` high, `loadData` is written into the instruction array (`loadToData`=0) or the data array (`loadToData`=1) at word index `loadAddr`. Byte address 4k maps to word k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| loadEn | input | 1 | Load strobe for the word arrays |
| loadToData | input | 1 | Load target: 0 selects the instruction array, 1 selects the data array |
| loadAddr | input | clog2(MEM_WORDS) | Word index for a load |
| loadData | input | 32 | Word to load |
| dbgRegAddr | input | 5 | Register number for the debug read |
| dbgRegData | output | 32 | Debug register value (combinational) |
| pcOut | output | 32 | Current program counter |

## Verification
Registers can only be filled from the data array, so every operand must first be preloaded as data and then fetched with loads. Stores and branches are observed only indirectly, through registers loaded afterwards and through the PC. The hardest case to reach is a store whose immediate has nonzero bits 15:11. The bench builds one with offset -8 and then checks that register 31 is still zero, so a store that wrongly wrote a register would show up. Each program ends in a self-branch, so the PC freezes at a known address and the final state can be read at leisure.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;

  localparam logic [5:0] FUNC_ADD = 6'h20;
  localparam logic [5:0] FUNC_SUB = 6'h22;
  localparam logic [5:0] FUNC_AND = 6'h24;
  localparam logic [5:0] FUNC_OR  = 6'h25;
  localparam logic [5:0] FUNC_SLT = 6'h2A;

  // operation class chosen by the main decoder
  typedef enum logic [1:0] {
    AOP_ADD   = 2'b00,
    AOP_SUB   = 2'b01,
    AOP_FUNCT = 2'b10
  } aluOp_e;

  typedef enum logic [2:0] {
    ALU_AND = 3'd0,
    ALU_OR  = 3'd1,
    ALU_ADD = 3'd2,
    ALU_SUB = 3'd3,
    ALU_SLT = 3'd4
  } aluFn_e;

  typedef struct packed {
    logic   regDst;
    logic   aluSrc;
    logic   memToReg;
    logic   regWrite;
    logic   memRead;
    logic   memWrite;
    logic   branch;
    aluOp_e aluOp;
    aluFn_e aluFn;
  } ctl_t;
endpackage

// File: rtl/sc_control.sv
module sc_control
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctl_t       ctl
);
  ctl_t   mainCtl;
  aluFn_e fnSel;

  // level 1: strobes and operation class from the opcode alone
  always_comb begin
    mainCtl       = '0;
    mainCtl.aluOp = AOP_ADD;
    mainCtl.aluFn = ALU_ADD;
    unique case (opcode)
      OP_RTYPE: begin
        mainCtl.regDst   = 1'b1;
        mainCtl.regWrite = 1'b1;
        mainCtl.aluOp    = AOP_FUNCT;
      end
      OP_LOAD: begin
        mainCtl.aluSrc   = 1'b1;
        mainCtl.memToReg = 1'b1;
        mainCtl.regWrite = 1'b1;
        mainCtl.memRead  = 1'b1;
      end
      OP_STORE: begin
        mainCtl.aluSrc   = 1'b1;
        mainCtl.memWrite = 1'b1;
      end
      OP_BEQ: begin
        mainCtl.branch = 1'b1;
        mainCtl.aluOp  = AOP_SUB;
      end
      default: ;
    endcase
  end

  // level 2: function field consulted only for the register-register class
  always_comb begin
    unique case (mainCtl.aluOp)
      AOP_SUB: fnSel = ALU_SUB;
      AOP_FUNCT: begin
        unique case (funct)
          FUNC_SUB: fnSel = ALU_SUB;
          FUNC_AND: fnSel = ALU_AND;
          FUNC_OR:  fnSel = ALU_OR;
          FUNC_SLT: fnSel = ALU_SLT;
          default:  fnSel = ALU_ADD;
        endcase
      end
      default: fnSel = ALU_ADD;
    endcase
  end

  always_comb begin
    ctl       = mainCtl;
    ctl.aluFn = fnSel;
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
(
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  input  aluFn_e          fn,
  output logic [XLEN-1:0] result,
  output logic            isZero
);
  always_comb begin
    unique case (fn)
      ALU_AND: result = opA & opB;
      ALU_OR:  result = opA | opB;
      ALU_SUB: result = opA - opB;
      ALU_SLT: result = {{(XLEN-1){1'b0}}, ($signed(opA) < $signed(opB))};
      default: result = opA + opB;
    endcase
  end

  assign isZero = (result == '0);
endmodule

// File: rtl/sc_datapath.sv
module sc_datapath
  import sc_pkg::*;
#(
  parameter int MEM_WORDS = 64,
  localparam int AW = $clog2(MEM_WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  ctl_t            ctl,
  input  logic            loadEn,
  input  logic            loadToData,
  input  logic [AW-1:0]   loadAddr,
  input  logic [XLEN-1:0] loadData,
  input  logic [4:0]      dbgRegAddr,
  output logic [XLEN-1:0] dbgRegData,
  output logic [XLEN-1:0] instr,
  output logic            aluZero,
  output logic [XLEN-1:0] pcOut
);
  localparam int NREG = 32;

  logic [XLEN-1:0] imem [MEM_WORDS];
  logic [XLEN-1:0] dmem [MEM_WORDS];
  logic [XLEN-1:0] regs [NREG];
  logic [XLEN-1:0] pc, pcPlus4, pcNext, immExt;
  logic [XLEN-1:0] rsVal, rtVal, aluB, aluRes, memRd, wbData;
  logic [4:0]      rsIdx, rtIdx, rdIdx, wrIdx;
  logic            unusedBits;

  assign instr   = imem[pc[AW+1:2]];
  assign rsIdx   = instr[25:21];
  assign rtIdx   = instr[20:16];
  assign rdIdx   = instr[15:11];
  assign immExt  = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign pcPlus4 = pc + 32'd4;

  assign rsVal = (rsIdx == 5'd0) ? '0 : regs[rsIdx];
  assign rtVal = (rtIdx == 5'd0) ? '0 : regs[rtIdx];
  assign dbgRegData = (dbgRegAddr == 5'd0) ? '0 : regs[dbgRegAddr];

  assign aluB = ctl.aluSrc ? immExt : rtVal;

  sc_alu u_alu (
    .opA    (rsVal),
    .opB    (aluB),
    .fn     (ctl.aluFn),
    .result (aluRes),
    .isZero (aluZero)
  );

  assign memRd  = dmem[aluRes[AW+1:2]];
  assign wbData = ctl.memToReg ? memRd : aluRes;
  assign wrIdx  = ctl.regDst ? rdIdx : rtIdx;
  assign pcNext = (ctl.branch && aluZero) ? pcPlus4 + {immExt[XLEN-3:0], 2'b00} : pcPlus4;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else        pc <= pcNext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (ctl.regWrite && wrIdx != 5'd0) begin
      regs[wrIdx] <= wbData;
    end
  end

  always_ff @(posedge clk) begin
    if (loadEn && !loadToData) imem[loadAddr] <= loadData;
  end

  always_ff @(posedge clk) begin
    if (loadEn && loadToData)          dmem[loadAddr] <= loadData;
    else if (rst_n && ctl.memWrite)    dmem[aluRes[AW+1:2]] <= rtVal;
  end

  assign pcOut = pc;
  assign unusedBits = ^{pc[XLEN-1:AW+2], pc[1:0], aluRes[XLEN-1:AW+2], aluRes[1:0],
                        ctl.memRead, ctl.aluOp};
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int MEM_WORDS = 64,
  localparam int LOAD_AW = $clog2(MEM_WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               loadEn,
  input  logic               loadToData,
  input  logic [LOAD_AW-1:0] loadAddr,
  input  logic [31:0]        loadData,
  input  logic [4:0]         dbgRegAddr,
  output logic [31:0]        dbgRegData,
  output logic [31:0]        pcOut
);
  ctl_t        ctl;
  logic [31:0] instr;
  logic        aluZero;

  sc_control u_ctl (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctl    (ctl)
  );

  sc_datapath #(.MEM_WORDS(MEM_WORDS)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl        (ctl),
    .loadEn     (loadEn),
    .loadToData (loadToData),
    .loadAddr   (loadAddr),
    .loadData   (loadData),
    .dbgRegAddr (dbgRegAddr),
    .dbgRegData (dbgRegData),
    .instr      (instr),
    .aluZero    (aluZero),
    .pcOut      (pcOut)
  );
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] pcOut,
  input logic [31:0] instr,
  input ctl_t        ctl,
  input logic        aluZero,
  input logic [4:0]  dbgRegAddr,
  input logic [31:0] dbgRegData
);
  logic        taken;
  logic        knownOp;
  logic [31:0] brOff;

  assign taken   = ctl.branch && aluZero;
  assign knownOp = (instr[31:26] == OP_RTYPE) || (instr[31:26] == OP_LOAD) ||
                   (instr[31:26] == OP_STORE) || (instr[31:26] == OP_BEQ);
  assign brOff   = {{14{instr[15]}}, instr[15:0], 2'b00};

  // R9
  a_r9_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    !taken |=> pcOut == $past(pcOut) + 32'd4);

  // R7
  a_r7_branch_target: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> pcOut == $past(pcOut) + 32'd4 + $past(brOff));

  // R10
  a_r10_unknown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !knownOp |-> !ctl.regWrite && !ctl.memWrite && !ctl.branch);

  // R6
  a_r6_store_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.memWrite |-> !ctl.regWrite && $onehot0({ctl.memRead, ctl.memWrite}));

  // R8
  a_r8_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
    dbgRegAddr == 5'd0 |-> dbgRegData == 32'd0);

  // R2
  a_r2_rtype_dest: assert property (@(posedge clk) disable iff (!rst_n)
    instr[31:26] == OP_RTYPE |-> ctl.regDst && ctl.regWrite && !ctl.aluSrc && !ctl.memToReg);

  // R1
  a_r1_pc_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    pcOut[1:0] == 2'b00);
endmodule

bind sc_core sc_core_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pcOut      (pcOut),
  .instr      (instr),
  .ctl        (ctl),
  .aluZero    (aluZero),
  .dbgRegAddr (dbgRegAddr),
  .dbgRegData (dbgRegData)
);

// File: tb/sim_sc_core.sv
`timescale 1ns/1ps
module sim_sc_core;
  localparam int WORDS = 64;
  localparam int AW = $clog2(WORDS);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          loadEn = 1'b0;
  logic          loadToData = 1'b0;
  logic [AW-1:0] loadAddr = '0;
  logic [31:0]   loadData = '0;
  logic [4:0]    dbgRegAddr = '0;
  logic [31:0]   dbgRegData;
  logic [31:0]   pcOut;

  int nChecks = 0;
  int nFails  = 0;

  logic [31:0] prog [WORDS];
  logic [31:0] dat  [WORDS];

  always #10 clk = ~clk;

  sc_core #(.MEM_WORDS(WORDS)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .loadEn     (loadEn),
    .loadToData (loadToData),
    .loadAddr   (loadAddr),
    .loadData   (loadData),
    .dbgRegAddr (dbgRegAddr),
    .dbgRegData (dbgRegData),
    .pcOut      (pcOut)
  );

  function automatic logic [31:0] rOp(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] iOp(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  localparam logic [31:0] HALT = {6'h04, 5'd0, 5'd0, 16'hFFFF};

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic readReg(logic [4:0] r, output logic [31:0] v);
    dbgRegAddr = r;
    #1;
    v = dbgRegData;
  endtask

  task automatic clearImages();
    for (int i = 0; i < WORDS; i++) begin
      prog[i] = HALT;
      dat[i]  = 32'd0;
    end
  endtask

  // holds reset, loads both arrays (R11), then releases reset on a falling edge
  task automatic loadAndStart();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < WORDS; i++) begin
      loadEn = 1'b1; loadToData = 1'b0; loadAddr = AW'(i); loadData = prog[i];
      @(negedge clk);
      loadToData = 1'b1; loadData = dat[i];
      @(negedge clk);
    end
    loadEn = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic testArith();
    logic [31:0] v;
    clearImages();
    dat[0] = 32'd7; dat[1] = 32'hFFFF_FFFD; dat[2] = 32'h0F0F_00FF; dat[3] = 32'h00FF_0F0F;
    prog[0]  = iOp(6'h23, 5'd0, 5'd1, 16'd0);
    prog[1]  = iOp(6'h23, 5'd0, 5'd2, 16'd4);
    prog[2]  = iOp(6'h23, 5'd0, 5'd3, 16'd8);
    prog[3]  = iOp(6'h23, 5'd0, 5'd4, 16'd12);
    prog[4]  = rOp(5'd1, 5'd2, 5'd5, 6'h20);
    prog[5]  = rOp(5'd1, 5'd2, 5'd6, 6'h22);
    prog[6]  = rOp(5'd3, 5'd4, 5'd7, 6'h24);
    prog[7]  = rOp(5'd3, 5'd4, 5'd8, 6'h25);
    prog[8]  = rOp(5'd2, 5'd1, 5'd9, 6'h2A);
    prog[9]  = rOp(5'd1, 5'd2, 5'd10, 6'h2A);
    prog[10] = rOp(5'd1, 5'd1, 5'd11, 6'h2A);
    prog[11] = rOp(5'd1, 5'd1, 5'd0, 6'h20);
    loadAndStart();
    check("R1 pc at release", pcOut, 32'd0);
    repeat (3) @(negedge clk);
    check("R9 pc after 3 clocks", pcOut, 32'd12);
    repeat (20) @(negedge clk);
    check("R7 halt self-branch pc", pcOut, 32'd48);
    readReg(5'd1, v);  check("R5 load r1", v, 32'd7);
    readReg(5'd5, v);  check("R2 add", v, 32'd4);
    readReg(5'd6, v);  check("R2 sub", v, 32'd10);
    readReg(5'd7, v);  check("R3 and", v, 32'h000F_000F);
    readReg(5'd8, v);  check("R3 or", v, 32'h0FFF_0FFF);
    readReg(5'd9, v);  check("R4 slt neg<pos", v, 32'd1);
    readReg(5'd10, v); check("R4 slt pos<neg", v, 32'd0);
    readReg(5'd11, v); check("R4 slt equal", v, 32'd0);
    readReg(5'd0, v);  check("R8 r0 after write", v, 32'd0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 pc in reset", pcOut, 32'd0);
    readReg(5'd5, v);  check("R1 reg cleared", v, 32'd0);
    readReg(5'd8, v);  check("R1 reg cleared r8", v, 32'd0);
  endtask

  task automatic testMemory();
    logic [31:0] v;
    clearImages();
    dat[4] = 32'd100; dat[5] = 32'hCAFE_BABE;
    prog[0] = iOp(6'h23, 5'd0, 5'd1, 16'd16);
    prog[1] = iOp(6'h23, 5'd0, 5'd2, 16'd20);
    prog[2] = iOp(6'h2B, 5'd1, 5'd2, 16'hFFF8);
    prog[3] = iOp(6'h23, 5'd1, 5'd3, 16'hFFF8);
    prog[4] = iOp(6'h23, 5'd0, 5'd4, 16'd92);
    loadAndStart();
    repeat (12) @(negedge clk);
    readReg(5'd1, v);  check("R5 load base", v, 32'd100);
    readReg(5'd3, v);  check("R5 load negative offset", v, 32'hCAFE_BABE);
    readReg(5'd4, v);  check("R6 stored word at 92", v, 32'hCAFE_BABE);
    readReg(5'd31, v); check("R6 store writes no register", v, 32'd0);
  endtask

  task automatic testBranch();
    logic [31:0] v;
    clearImages();
    dat[0] = 32'd5; dat[1] = 32'd5; dat[2] = 32'd9;
    prog[0] = iOp(6'h23, 5'd0, 5'd1, 16'd0);
    prog[1] = iOp(6'h23, 5'd0, 5'd2, 16'd4);
    prog[2] = iOp(6'h23, 5'd0, 5'd3, 16'd8);
    prog[3] = iOp(6'h04, 5'd1, 5'd3, 16'd5);
    prog[4] = iOp(6'h04, 5'd1, 5'd2, 16'd2);
    prog[5] = iOp(6'h23, 5'd0, 5'd4, 16'd0);
    prog[6] = iOp(6'h23, 5'd0, 5'd5, 16'd0);
    prog[7] = iOp(6'h23, 5'd0, 5'd6, 16'd8);
    loadAndStart();
    repeat (4) @(negedge clk);
    check("R7 not-taken pc", pcOut, 32'd16);
    @(negedge clk);
    check("R7 taken pc", pcOut, 32'd28);
    repeat (10) @(negedge clk);
    check("R7 backward self-branch pc", pcOut, 32'd32);
    readReg(5'd4, v); check("R7 skipped r4", v, 32'd0);
    readReg(5'd5, v); check("R7 skipped r5", v, 32'd0);
    readReg(5'd6, v); check("R7 target executed r6", v, 32'd9);
  endtask

  task automatic testUnknown();
    logic [31:0] v;
    clearImages();
    dat[0] = 32'd11; dat[1] = 32'h55;
    prog[0] = iOp(6'h23, 5'd0, 5'd1, 16'd0);
    prog[1] = iOp(6'h08, 5'd0, 5'd2, 16'd5);
    prog[2] = iOp(6'h05, 5'd1, 5'd0, 16'd4);
    prog[3] = iOp(6'h28, 5'd0, 5'd1, 16'd4);
    prog[4] = iOp(6'h23, 5'd0, 5'd3, 16'd4);
    loadAndStart();
    repeat (3) @(negedge clk);
    check("R10 pc past unknown branch-like op", pcOut, 32'd12);
    repeat (10) @(negedge clk);
    readReg(5'd2, v); check("R10 no register write", v, 32'd0);
    readReg(5'd3, v); check("R10 no data write", v, 32'h55);
    readReg(5'd1, v); check("R11 data load", v, 32'd11);
  endtask

  initial begin
    #4_000_000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 pc under reset", pcOut, 32'd0);
    testArith();
    testMemory();
    testBranch();
    testUnknown();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule